// File: doc/BRIEF.md
# Hard-Decision Viterbi Add-Compare-Select Stage

This block is the metric engine of a hard-decision Viterbi decoder for the four-state, rate one-half convolutional code with constraint length three and generator taps 111 and 101. Each cycle that `in_valid` is high, it takes one received two-bit code symbol. It scores that symbol against the expected label of all eight trellis branches by Hamming distance. It adds each score to the stored metric of the branch's source state and keeps, for every destination state, the cheaper of its two incoming candidates.

The surviving metrics are written back into an internal four-entry metric store. The block reports one survivor decision bit per state for a downstream traceback unit, the four stored metrics, and the index of the cheapest state. Decoding assumes that the encoder starts in the all-zero state. Metrics are kept inside their width by a common subtraction that does not change which state is cheapest.

Top module: `vacs_unit`

## Requirements
- R1: While reset is asserted, and up to the first accepted symbol after it, the stored metrics are 0 for state 0 and `INIT_PM` (default 16) for states 1, 2 and 3. `dec` is 0000, `out_valid` is 0 and `min_state` is 0. An asserted reset takes effect at once. Its release takes effect after two rising clock edges.
- R2: A state is numbered `s[1:0]`. Input bit u moves the encoder from state s to state {u, s[1]}. The branch label is {u^s[1]^s[0], u^s[0]}, with bit 1 of `rx_sym` holding the first (111) output. Starting from the zero state with an error-free stream, the true encoder state has metric 0 and is reported by `min_state`.
- R3: The branch metric is the Hamming distance (0, 1 or 2) between `rx_sym` and a branch label. Each destination state stores the smaller of (predecessor metric + branch metric) over its two predecessors, {n[0],0} and {n[0],1}.
- R4: `dec[n]` is the low bit of the winning predecessor of state n. When both candidates are equal, the predecessor with low bit 0 wins and `dec[n]` is 0.
- R5: Metrics are `PM_W` bits wide (default 6). When all four new metrics have their top bit set, that bit is cleared in all four before they are stored. A stored set of metrics therefore never has all four top bits set.
- R6: A cycle with `in_valid` low leaves the stored metrics and `dec` unchanged, whatever the value of `rx_sym`.
- R7: `out_valid` is high in exactly the cycle after each cycle with `in_valid` high. `dec` and `pm_flat` show the result of that update from the same edge.
- R8: `min_state` is the index of the smallest stored metric, taken from the stored values. On a tie it gives the lowest index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| in_valid | input | 1 | Received symbol is present this cycle |
| rx_sym | input | 2 | Received hard-decision code symbol, bit 1 = 111 output |
| out_valid | output | 1 | Update results are present |
| dec | output | 4 | Survivor decision bit per destination state |
| pm_flat | output | 4*PM_W | Stored metrics, state n in bits [n*PM_W +: PM_W] |
| min_state | output | 2 | Index of the cheapest stored state |

## Verification
The state of this block is the metric store, and the store is visible on `pm_flat` in the cycle after each accepted symbol. Because of that, a wrong sum, a swapped branch label or a wrong tie choice shows up at the port on the very next update. It also spreads into every later update through the recursion. A normalisation fault appears only when the lowest metric crosses half of the range, so the bench drives a long noisy stream to cross that point several times. A fault in the hold path appears on the first idle cycle that carries a non-zero symbol.

// File: rtl/vacs_pkg.sv
package vacs_pkg;
  localparam int NUM_ST = 4;
  localparam int ST_W   = 2;

  // Expected code symbol on the branch leaving state s with input u.
  function automatic logic [1:0] exp_sym(input logic [1:0] s, input logic u);
    logic [1:0] r;
    case ({s, u})
      3'b000: r = 2'b00;
      3'b001: r = 2'b11;
      3'b010: r = 2'b11;
      3'b011: r = 2'b00;
      3'b100: r = 2'b10;
      3'b101: r = 2'b01;
      3'b110: r = 2'b01;
      default: r = 2'b10;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/vacs_rst_sync.sv
module vacs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/vacs_branch_metric.sv
module vacs_branch_metric (
  input  logic [1:0]       rx_sym,
  output logic [3:0][1:0]  dist_by_label
);
  // One Hamming distance for each of the four possible labels.
  always_comb begin
    for (int l = 0; l < 4; l++) begin
      logic [1:0] diff;
      diff = rx_sym ^ 2'(l);
      dist_by_label[l] = 2'(diff[1]) + 2'(diff[0]);
    end
  end
endmodule

// File: rtl/vacs_acs_cell.sv
module vacs_acs_cell #(
  parameter int PM_W = 6
) (
  input  logic [PM_W-1:0] pm_even,
  input  logic [1:0]      bm_even,
  input  logic [PM_W-1:0] pm_odd,
  input  logic [1:0]      bm_odd,
  output logic [PM_W-1:0] pm_new,
  output logic            pick_odd
);
  logic [PM_W-1:0] cand_even, cand_odd;

  always_comb begin
    cand_even = pm_even + PM_W'(bm_even);
    cand_odd  = pm_odd  + PM_W'(bm_odd);
    pick_odd  = (cand_odd < cand_even);
    pm_new    = pick_odd ? cand_odd : cand_even;
  end
endmodule

// File: rtl/vacs_min_sel.sv
module vacs_min_sel #(
  parameter int PM_W = 6,
  parameter int N    = 4,
  localparam int IW  = $clog2(N)
) (
  input  logic [N-1:0][PM_W-1:0] metrics,
  output logic [IW-1:0]          idx
);
  always_comb begin
    idx = '0;
    for (int i = 1; i < N; i++) begin
      if (metrics[i] < metrics[idx]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/vacs_unit.sv
module vacs_unit #(
  parameter int PM_W    = 6,
  parameter int INIT_PM = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           in_valid,
  input  logic [1:0]                     rx_sym,
  output logic                           out_valid,
  output logic [vacs_pkg::NUM_ST-1:0]    dec,
  output logic [vacs_pkg::NUM_ST*PM_W-1:0] pm_flat,
  output logic [vacs_pkg::ST_W-1:0]      min_state
);
  import vacs_pkg::*;

  localparam int NS = NUM_ST;

  logic rst_sync_n;
  logic [3:0][1:0]         dist_tab;
  logic [NS-1:0][PM_W-1:0] pm_q, pm_d, pm_acs, pm_norm;
  logic [NS-1:0]           dec_q, dec_d, dec_acs;
  logic                    ov_q, ov_d;
  logic                    all_top;

  vacs_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  vacs_branch_metric u_bm (
    .rx_sym        (rx_sym),
    .dist_by_label (dist_tab)
  );

  for (genvar n = 0; n < NS; n++) begin : g_st
    localparam logic [1:0] PRED_E = 2'((n % 2) * 2);
    localparam logic [1:0] PRED_O = 2'((n % 2) * 2 + 1);
    localparam logic       BIT_U  = 1'(n / 2);
    localparam logic [1:0] LAB_E  = exp_sym(PRED_E, BIT_U);
    localparam logic [1:0] LAB_O  = exp_sym(PRED_O, BIT_U);

    vacs_acs_cell #(.PM_W(PM_W)) u_acs (
      .pm_even  (pm_q[PRED_E]),
      .bm_even  (dist_tab[LAB_E]),
      .pm_odd   (pm_q[PRED_O]),
      .bm_odd   (dist_tab[LAB_O]),
      .pm_new   (pm_acs[n]),
      .pick_odd (dec_acs[n])
    );
  end

  // Common subtraction of half the range once every metric passes it.
  always_comb begin
    all_top = 1'b1;
    for (int n = 0; n < NS; n++) all_top &= pm_acs[n][PM_W-1];
    for (int n = 0; n < NS; n++) begin
      pm_norm[n] = pm_acs[n];
      if (all_top) pm_norm[n][PM_W-1] = 1'b0;
    end
  end

  always_comb begin
    pm_d  = pm_q;
    dec_d = dec_q;
    ov_d  = in_valid;
    if (in_valid) begin
      pm_d  = pm_norm;
      dec_d = dec_acs;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      for (int n = 0; n < NS; n++)
        pm_q[n] <= (n == 0) ? '0 : PM_W'(INIT_PM);
      dec_q <= '0;
      ov_q  <= 1'b0;
    end else begin
      ov_q <= ov_d;
      if (in_valid) begin
        pm_q  <= pm_d;
        dec_q <= dec_d;
      end
    end
  end

  vacs_min_sel #(.PM_W(PM_W), .N(NS)) u_min (
    .metrics (pm_q),
    .idx     (min_state)
  );

  assign out_valid = ov_q;
  assign dec       = dec_q;
  assign pm_flat   = pm_q;
endmodule

// File: rtl/vacs_unit_chk.sv
module vacs_unit_chk #(
  parameter int PM_W = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            out_valid,
  input logic [3:0]      dec,
  input logic [4*PM_W-1:0] pm_flat,
  input logic [1:0]      min_state
);
  logic all_top_stored;
  logic min_ok;
  logic [PM_W-1:0] min_val;

  always_comb begin
    all_top_stored = 1'b1;
    for (int n = 0; n < 4; n++) all_top_stored &= pm_flat[n*PM_W + PM_W - 1];
    min_val = pm_flat[min_state*PM_W +: PM_W];
    min_ok  = 1'b1;
    for (int n = 0; n < 4; n++) begin
      if (pm_flat[n*PM_W +: PM_W] < min_val) min_ok = 1'b0;
      if ((n < int'(min_state)) && (pm_flat[n*PM_W +: PM_W] == min_val)) min_ok = 1'b0;
    end
  end

  AST_HOLD_METRICS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(pm_flat)); // R6
  AST_HOLD_DECISIONS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(dec)); // R6
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R7
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !all_top_stored); // R5
  AST_MIN_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    min_ok); // R8
endmodule

bind vacs_unit vacs_unit_chk #(.PM_W(PM_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .dec       (dec),
  .pm_flat   (pm_flat),
  .min_state (min_state)
);

// File: tb/vacs_unit_test.sv
module vacs_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int W    = 6;
  localparam int INIT = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [1:0] rx_sym = 2'b00;
  logic out_valid;
  logic [3:0] dec;
  logic [4*W-1:0] pm_flat;
  logic [1:0] min_state;

  int checks = 0;
  int errors = 0;
  int mpm[4];
  logic [3:0] mdec;
  int norm_count = 0;
  logic [1:0] enc_st;
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  vacs_unit #(.PM_W(W), .INIT_PM(INIT)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .rx_sym(rx_sym),
    .out_valid(out_valid), .dec(dec), .pm_flat(pm_flat), .min_state(min_state)
  );

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] label(input int s, input int u);
    logic [1:0] st;
    st = 2'(s);
    return {1'(u) ^ st[1] ^ st[0], 1'(u) ^ st[0]};
  endfunction

  function automatic int ham(input logic [1:0] a, input logic [1:0] b);
    logic [1:0] d;
    d = a ^ b;
    return int'(d[1]) + int'(d[0]);
  endfunction

  function automatic logic [4*W-1:0] model_vec();
    logic [4*W-1:0] v;
    for (int n = 0; n < 4; n++) v[n*W +: W] = W'(mpm[n]);
    return v;
  endfunction

  function automatic logic [1:0] model_min();
    int b;
    b = 0;
    for (int n = 1; n < 4; n++) if (mpm[n] < mpm[b]) b = n;
    return 2'(b);
  endfunction

  task automatic model_reset();
    mpm[0] = 0; mpm[1] = INIT; mpm[2] = INIT; mpm[3] = INIT;
    mdec = 4'b0000;
  endtask

  task automatic model_update(input logic [1:0] sym);
    int nw[4];
    int top;
    top = 1;
    for (int n = 0; n < 4; n++) begin
      int pe, po, u, ce, co;
      pe = (n % 2) * 2; po = pe + 1; u = n / 2;
      ce = mpm[pe] + ham(sym, label(pe, u));
      co = mpm[po] + ham(sym, label(po, u));
      if (co < ce) begin nw[n] = co; mdec[n] = 1'b1; end
      else begin nw[n] = ce; mdec[n] = 1'b0; end
      if (nw[n] < (1 << (W-1))) top = 0;
    end
    if (top != 0) norm_count++;
    for (int n = 0; n < 4; n++) mpm[n] = (top != 0) ? nw[n] - (1 << (W-1)) : nw[n];
  endtask

  // Starts and ends at a falling edge.
  task automatic step(input logic v, input logic [1:0] sym);
    in_valid = v;
    rx_sym = sym;
    @(posedge clk);
    if (v) model_update(sym);
    @(negedge clk);
    chk(pm_flat == model_vec(), "R3 metrics", 64'(pm_flat), 64'(model_vec()));
    chk(dec == mdec, "R4 decisions", 64'(dec), 64'(mdec));
    chk(out_valid == v, "R7 out_valid", 64'(out_valid), 64'(v));
    chk(min_state == model_min(), "R8 min_state", 64'(min_state), 64'(model_min()));
  endtask

  task automatic do_reset();
    in_valid = 1'b0;
    rx_sym = 2'b00;
    rst_n = 1'b0;
    model_reset();
    enc_st = 2'b00;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic test_reset();
    do_reset();
    chk(pm_flat == {W'(INIT), W'(INIT), W'(INIT), W'(0)}, "R1 metrics", 64'(pm_flat), 64'({W'(INIT), W'(INIT), W'(INIT), W'(0)}));
    chk(dec == 4'b0000, "R1 dec", 64'(dec), 64'h0);
    chk(out_valid == 1'b0, "R1 out_valid", 64'(out_valid), 64'h0);
    chk(min_state == 2'd0, "R1 min_state", 64'(min_state), 64'h0);
  endtask

  task automatic test_tie();
    do_reset();
    step(1'b1, 2'b00);
    chk(pm_flat == {W'(17), W'(2), W'(17), W'(0)}, "R4 tie metrics", 64'(pm_flat), 64'({W'(17), W'(2), W'(17), W'(0)}));
    chk(dec == 4'b0000, "R4 tie prefers even predecessor", 64'(dec), 64'h0);
  endtask

  task automatic send_bit(input int u, input logic [1:0] flip);
    logic [1:0] sym;
    sym = label(int'(enc_st), u) ^ flip;
    enc_st = {1'(u), enc_st[1]};
    step(1'b1, sym);
  endtask

  task automatic test_clean();
    do_reset();
    for (int i = 0; i < 40; i++) begin
      send_bit(int'(lfsr[0]), 2'b00);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (i >= 3) begin
        chk(min_state == enc_st, "R2 true state is cheapest", 64'(min_state), 64'(enc_st));
        chk(pm_flat[enc_st*W +: W] == '0, "R2 true state metric zero", 64'(pm_flat[enc_st*W +: W]), 64'h0);
      end
    end
  endtask

  task automatic test_errors();
    do_reset();
    for (int i = 0; i < 60; i++) begin
      logic [1:0] f;
      f = (i % 7 == 3) ? 2'b10 : ((i % 11 == 5) ? 2'b01 : 2'b00);
      send_bit(int'(lfsr[1]), f);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    end
  endtask

  task automatic test_hold();
    logic [4*W-1:0] snap;
    logic [3:0] dsnap;
    do_reset();
    step(1'b1, 2'b10);
    step(1'b1, 2'b01);
    snap = pm_flat;
    dsnap = dec;
    for (int i = 0; i < 4; i++) step(1'b0, 2'(i));
    chk(pm_flat == snap, "R6 metrics held", 64'(pm_flat), 64'(snap));
    chk(dec == dsnap, "R6 decisions held", 64'(dec), 64'(dsnap));
    step(1'b1, 2'b11);
  endtask

  task automatic test_norm();
    do_reset();
    norm_count = 0;
    for (int i = 0; i < 400; i++) begin
      step(1'b1, lfsr[1:0]);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (i % 37 == 0) step(1'b0, 2'b11);
    end
    chk(norm_count > 1, "R5 normalisation exercised", 64'(norm_count), 64'd2);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    test_reset();
    test_tie();
    test_clean();
    test_errors();
    test_hold();
    test_norm();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule